// File: doc/BRIEF.md
# Connection CAM with Automatic Slot Allocation

This block is the connection store of a time-slot interchanger. Each entry links a key (a stream number and a time-slot number) to a tag. The tag is a pointer into the bus data memory, or it is the pattern byte itself. Each entry also holds three control bits (transfer direction, pattern enable and delay-buffer select), a subrate field and an internal empty flag. Host logic sends three kinds of command:

- **Make** fills the lowest-numbered empty entry and reports the location it chose. No address is supplied.
- **Break** finds an entry by its key and frees it.
- **Query** reads back one entry by its physical index.

Separately, every frame slot presents a key on the lookup port. One clock later the block returns the tag and control bits of the matching connection. For a pattern connection, the block marks the tag as outgoing data. For a normal connection, it marks the tag as a memory pointer.

Top module: `conn_cam`

## Requirements
- R1: After reset every entry is empty and holds zero data. `cam_full`, `rsp_valid` and `lk_hit` are low.
- R2: A command with `cmd_op`=01 (make) writes the key, tag, control bits and subrate field into the lowest-numbered empty entry. One cycle later it sets `rsp_valid` and `rsp_ok` and reports that index on `rsp_loc`, with the written fields on the response outputs.
- R3: `cam_full` is high exactly when no entry is empty. A make while full changes no entry. One cycle later it sets `rsp_valid` and `rsp_full`, with `rsp_ok` low and all other response fields zero.
- R4: A command with `cmd_op`=10 (break) searches only on stream and time slot. It frees the lowest-numbered occupied entry with that key and, one cycle later, reports that entry's index and stored fields with `rsp_ok` high. When nothing matches, `rsp_ok` is low, all other response fields are zero and no entry changes.
- R5: A command with `cmd_op`=11 (query) returns, one cycle later, the stored fields and the empty flag (`rsp_empty`) of the entry at `cmd_loc`, with `rsp_ok` high. A query or a lookup changes no entry.
- R6: A key presented with `lk_valid` gives a registered result in the next cycle. That result is `lk_hit`, `lk_loc` and the entry's tag, direction, delay select and subrate. On a miss, or without `lk_valid`, all lookup outputs are zero.
- R7: When several occupied entries hold the same key, both lookups and breaks pick the lowest-numbered one.
- R8: On a hit to an entry whose pattern bit is 1, `lk_pat_en` is high and `lk_mem_en` is low, so the tag is output data. On a hit to an entry whose pattern bit is 0, `lk_mem_en` is high and `lk_pat_en` is low.
- R9: A lookup and a command in the same cycle give a lookup result based on the entry contents before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 idle, 01 make, 10 break, 11 query |
| cmd_stream | input | STREAM_W | Key stream number |
| cmd_slot | input | SLOT_W | Key time-slot number |
| cmd_tag | input | TAG_W | Tag to store on make |
| cmd_dir | input | 1 | Direction bit to store (1 = drive bus) |
| cmd_pat | input | 1 | Pattern-enable bit to store |
| cmd_dly | input | 1 | Delay-buffer select to store |
| cmd_sub | input | SUB_W | Subrate field to store |
| cmd_loc | input | IDX_W | Entry index for query |
| rsp_valid | output | 1 | Response strobe, one cycle after a command |
| rsp_ok | output | 1 | Command succeeded |
| rsp_full | output | 1 | Make refused because no entry was empty |
| rsp_loc | output | IDX_W | Entry index allocated, freed or queried |
| rsp_empty | output | 1 | Empty flag of the queried entry |
| rsp_stream | output | STREAM_W | Entry stream number |
| rsp_slot | output | SLOT_W | Entry time-slot number |
| rsp_tag | output | TAG_W | Entry tag |
| rsp_dir | output | 1 | Entry direction bit |
| rsp_pat | output | 1 | Entry pattern bit |
| rsp_dly | output | 1 | Entry delay select |
| rsp_sub | output | SUB_W | Entry subrate field |
| lk_valid | input | 1 | Lookup strobe |
| lk_stream | input | STREAM_W | Lookup stream number |
| lk_slot | input | SLOT_W | Lookup time-slot number |
| lk_hit | output | 1 | Lookup matched an occupied entry |
| lk_loc | output | IDX_W | Index of the matching entry |
| lk_tag | output | TAG_W | Stored tag (pointer or pattern data) |
| lk_dir | output | 1 | Stored direction bit |
| lk_dly | output | 1 | Stored delay select |
| lk_sub | output | SUB_W | Stored subrate field |
| lk_mem_en | output | 1 | Hit, tag is a data-memory pointer |
| lk_pat_en | output | 1 | Hit, tag is pattern output data |
| cam_full | output | 1 | No empty entry remains |

## Verification
Some properties are checked on every cycle:

- A write always lands in its entry and clears that entry's empty flag.
- A free sets the flag.
- Without a make or a break, the flag vector never moves.
- A make while full is always refused.
- The lookup hit agrees with the match vector one cycle earlier.
- Pointer use and pattern use never occur together.

Other behaviour can only be shown by the bench's scenarios. That covers the choice of the lowest empty or lowest matching entry, the refill of a hole left by a break, and lookups seeing the contents from before a command in the same cycle. A reference model tracks every entry and is compared against the outputs on every clock.

// File: rtl/conn_cam_pkg.sv
package conn_cam_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_MAKE  = 2'b01,
      OP_BREAK = 2'b10,
      OP_QUERY = 2'b11
   } cam_op_e;

   // Control bits as held inside an entry, LSB first: dir, pat, dly
   typedef struct packed {
      logic dly;
      logic pat;
      logic dir;
   } cam_ctrl_t;

   localparam int CTRL_W = $bits(cam_ctrl_t);

endpackage

// File: rtl/conn_cam_first.sv
// Lowest-index-first priority encoder
module conn_cam_first #(
   parameter  int N     = 512,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   if (N < 2) begin : g_bad_n
      $error("conn_cam_first: N must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/conn_cam_array.sv
// Entry storage, empty flags and two parallel key comparators
module conn_cam_array #(
   parameter  int DEPTH = 512,
   parameter  int KEY_W = 12,
   parameter  int ENT_W = 26,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic [KEY_W-1:0] key_a,
   input  logic [KEY_W-1:0] key_b,
   output logic [DEPTH-1:0] match_a,
   output logic [DEPTH-1:0] match_b,
   output logic [DEPTH-1:0] empty_vec,
   input  logic [IDX_W-1:0] rd_idx_a,
   output logic [ENT_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0] rd_idx_b,
   output logic [ENT_W-1:0] rd_data_b
);

   if ((2 ** IDX_W) != DEPTH) begin : g_bad_depth
      $error("conn_cam_array: DEPTH must be a power of two");
   end
   if (KEY_W >= ENT_W) begin : g_bad_key
      $error("conn_cam_array: key must be narrower than the entry");
   end

   logic [ENT_W-1:0] ent_q [DEPTH];
   logic [DEPTH-1:0] empty_q;
   logic [DEPTH-1:0] empty_nxt;

   always_comb begin
      empty_nxt = empty_q;
      if (clr_en) empty_nxt[clr_idx] = 1'b1;
      if (wr_en)  empty_nxt[wr_idx]  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= '1;
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
      end else begin
         empty_q <= empty_nxt;
         if (wr_en) ent_q[wr_idx] <= wr_data;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_a[g] = !empty_q[g] && (ent_q[g][KEY_W-1:0] == key_a);
      assign match_b[g] = !empty_q[g] && (ent_q[g][KEY_W-1:0] == key_b);
   end

   assign empty_vec = empty_q;
   assign rd_data_a = ent_q[rd_idx_a];
   assign rd_data_b = ent_q[rd_idx_b];

   // R2
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!empty_q[$past(wr_idx)] && ent_q[$past(wr_idx)] == $past(wr_data)));

   // R4
   clr_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(wr_en && wr_idx == clr_idx)) |=> empty_q[$past(clr_idx)]);

   // R5
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr_en) |=> $stable(empty_q));

endmodule

// File: rtl/conn_cam.sv
// Connection CAM: make / break / query commands plus a per-slot lookup
module conn_cam
   import conn_cam_pkg::*;
#(
   parameter  int DEPTH    = 512,
   parameter  int STREAM_W = 5,
   parameter  int SLOT_W   = 7,
   parameter  int TAG_W    = 9,
   parameter  int SUB_W    = 2,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [1:0]          cmd_op,
   input  logic [STREAM_W-1:0] cmd_stream,
   input  logic [SLOT_W-1:0]   cmd_slot,
   input  logic [TAG_W-1:0]    cmd_tag,
   input  logic                cmd_dir,
   input  logic                cmd_pat,
   input  logic                cmd_dly,
   input  logic [SUB_W-1:0]    cmd_sub,
   input  logic [IDX_W-1:0]    cmd_loc,
   output logic                rsp_valid,
   output logic                rsp_ok,
   output logic                rsp_full,
   output logic [IDX_W-1:0]    rsp_loc,
   output logic                rsp_empty,
   output logic [STREAM_W-1:0] rsp_stream,
   output logic [SLOT_W-1:0]   rsp_slot,
   output logic [TAG_W-1:0]    rsp_tag,
   output logic                rsp_dir,
   output logic                rsp_pat,
   output logic                rsp_dly,
   output logic [SUB_W-1:0]    rsp_sub,
   input  logic                lk_valid,
   input  logic [STREAM_W-1:0] lk_stream,
   input  logic [SLOT_W-1:0]   lk_slot,
   output logic                lk_hit,
   output logic [IDX_W-1:0]    lk_loc,
   output logic [TAG_W-1:0]    lk_tag,
   output logic                lk_dir,
   output logic                lk_dly,
   output logic [SUB_W-1:0]    lk_sub,
   output logic                lk_mem_en,
   output logic                lk_pat_en,
   output logic                cam_full
);

   localparam int KEY_W    = STREAM_W + SLOT_W;
   localparam int OFF_SLOT = STREAM_W;
   localparam int OFF_TAG  = KEY_W;
   localparam int OFF_CTRL = KEY_W + TAG_W;
   localparam int OFF_SUB  = OFF_CTRL + CTRL_W;
   localparam int ENT_W    = OFF_SUB + SUB_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("conn_cam: DEPTH must be at least 2");
   end
   if (STREAM_W < 1 || SLOT_W < 1 || TAG_W < 1 || SUB_W < 1) begin : g_bad_w
      $error("conn_cam: all field widths must be at least 1");
   end

   cam_op_e op;
   assign op = cam_op_e'(cmd_op);

   logic [KEY_W-1:0] key_cmd, key_lk;
   logic [ENT_W-1:0] new_ent;
   cam_ctrl_t        new_ctrl;

   assign key_cmd  = {cmd_slot, cmd_stream};
   assign key_lk   = {lk_slot, lk_stream};
   assign new_ctrl = '{dly: cmd_dly, pat: cmd_pat, dir: cmd_dir};
   assign new_ent  = {cmd_sub, new_ctrl, cmd_tag, key_cmd};

   logic [DEPTH-1:0] match_cmd, match_lk, empty_vec;
   logic             free_found, brk_found, lkm_found;
   logic [IDX_W-1:0] free_idx, brk_idx, lkm_idx, rd_idx_a;
   logic [ENT_W-1:0] rd_ent_a, rd_ent_b;
   logic             wr_en, clr_en;

   assign wr_en    = cmd_valid && (op == OP_MAKE) && free_found;
   assign clr_en   = cmd_valid && (op == OP_BREAK) && brk_found;
   assign rd_idx_a = (op == OP_QUERY) ? cmd_loc : brk_idx;
   assign cam_full = ~|empty_vec;

   conn_cam_array #(.DEPTH(DEPTH), .KEY_W(KEY_W), .ENT_W(ENT_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (free_idx),
      .wr_data   (new_ent),
      .clr_en    (clr_en),
      .clr_idx   (brk_idx),
      .key_a     (key_cmd),
      .key_b     (key_lk),
      .match_a   (match_cmd),
      .match_b   (match_lk),
      .empty_vec (empty_vec),
      .rd_idx_a  (rd_idx_a),
      .rd_data_a (rd_ent_a),
      .rd_idx_b  (lkm_idx),
      .rd_data_b (rd_ent_b)
   );

   conn_cam_first #(.N(DEPTH)) u_free (
      .vec (empty_vec), .found (free_found), .idx (free_idx));
   conn_cam_first #(.N(DEPTH)) u_brk (
      .vec (match_cmd), .found (brk_found), .idx (brk_idx));
   conn_cam_first #(.N(DEPTH)) u_lkm (
      .vec (match_lk), .found (lkm_found), .idx (lkm_idx));

   // Response selection
   logic             rsp_ok_c, rsp_full_c, rsp_empty_c;
   logic [IDX_W-1:0] rsp_loc_c;
   logic [ENT_W-1:0] rsp_ent_c;

   always_comb begin
      rsp_ok_c    = 1'b0;
      rsp_full_c  = 1'b0;
      rsp_empty_c = 1'b0;
      rsp_loc_c   = '0;
      rsp_ent_c   = '0;
      unique case (op)
         OP_MAKE: begin
            rsp_ok_c   = free_found;
            rsp_full_c = !free_found;
            if (free_found) begin
               rsp_loc_c = free_idx;
               rsp_ent_c = new_ent;
            end
         end
         OP_BREAK: begin
            rsp_ok_c = brk_found;
            if (brk_found) begin
               rsp_loc_c = brk_idx;
               rsp_ent_c = rd_ent_a;
            end
         end
         OP_QUERY: begin
            rsp_ok_c    = 1'b1;
            rsp_loc_c   = cmd_loc;
            rsp_ent_c   = rd_ent_a;
            rsp_empty_c = empty_vec[cmd_loc];
         end
         default: ;
      endcase
   end

   logic [ENT_W-1:0] rsp_ent_q;
   cam_ctrl_t        rsp_ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n || !cmd_valid || op == OP_IDLE) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_full  <= 1'b0;
         rsp_empty <= 1'b0;
         rsp_loc   <= '0;
         rsp_ent_q <= '0;
      end else begin
         rsp_valid <= 1'b1;
         rsp_ok    <= rsp_ok_c;
         rsp_full  <= rsp_full_c;
         rsp_empty <= rsp_empty_c;
         rsp_loc   <= rsp_loc_c;
         rsp_ent_q <= rsp_ent_c;
      end
   end

   assign rsp_ctrl   = cam_ctrl_t'(rsp_ent_q[OFF_SUB-1:OFF_CTRL]);
   assign rsp_stream = rsp_ent_q[OFF_SLOT-1:0];
   assign rsp_slot   = rsp_ent_q[OFF_TAG-1:OFF_SLOT];
   assign rsp_tag    = rsp_ent_q[OFF_CTRL-1:OFF_TAG];
   assign rsp_dir    = rsp_ctrl.dir;
   assign rsp_pat    = rsp_ctrl.pat;
   assign rsp_dly    = rsp_ctrl.dly;
   assign rsp_sub    = rsp_ent_q[ENT_W-1:OFF_SUB];

   // Lookup pipeline register: result sampled from pre-command contents
   logic             lk_take;
   cam_ctrl_t        lk_ctrl_c;

   assign lk_take   = lk_valid && lkm_found;
   assign lk_ctrl_c = cam_ctrl_t'(rd_ent_b[OFF_SUB-1:OFF_CTRL]);

   always_ff @(posedge clk) begin
      if (!rst_n || !lk_take) begin
         lk_hit    <= 1'b0;
         lk_loc    <= '0;
         lk_tag    <= '0;
         lk_dir    <= 1'b0;
         lk_dly    <= 1'b0;
         lk_sub    <= '0;
         lk_mem_en <= 1'b0;
         lk_pat_en <= 1'b0;
      end else begin
         lk_hit    <= 1'b1;
         lk_loc    <= lkm_idx;
         lk_tag    <= rd_ent_b[OFF_CTRL-1:OFF_TAG];
         lk_dir    <= lk_ctrl_c.dir;
         lk_dly    <= lk_ctrl_c.dly;
         lk_sub    <= rd_ent_b[ENT_W-1:OFF_SUB];
         lk_mem_en <= !lk_ctrl_c.pat;
         lk_pat_en <= lk_ctrl_c.pat;
      end
   end

   // R3
   full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_MAKE && cam_full) |=> (rsp_valid && rsp_full && !rsp_ok));

   // R2
   make_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == OP_MAKE && !cam_full) |=> (rsp_valid && rsp_ok && !rsp_full));

   // R6
   lk_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (lk_hit == $past(|match_lk)));

   // R8
   lk_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_mem_en, lk_pat_en}) && (lk_hit == (lk_mem_en || lk_pat_en)));

endmodule

// File: tb/conn_cam_bench.sv
`timescale 1ns/1ps
module conn_cam_bench;

   localparam int DEPTH = 512;
   localparam int SW = 5, TW = 7, GW = 9, UW = 2;
   localparam int IW = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          cmd_valid = 0;
   logic [1:0]    cmd_op = 0;
   logic [SW-1:0] cmd_stream = 0;
   logic [TW-1:0] cmd_slot = 0;
   logic [GW-1:0] cmd_tag = 0;
   logic          cmd_dir = 0, cmd_pat = 0, cmd_dly = 0;
   logic [UW-1:0] cmd_sub = 0;
   logic [IW-1:0] cmd_loc = 0;
   logic          lk_valid = 0;
   logic [SW-1:0] lk_stream = 0;
   logic [TW-1:0] lk_slot = 0;

   logic          rsp_valid, rsp_ok, rsp_full, rsp_empty, rsp_dir, rsp_pat, rsp_dly;
   logic [IW-1:0] rsp_loc, lk_loc;
   logic [SW-1:0] rsp_stream;
   logic [TW-1:0] rsp_slot;
   logic [GW-1:0] rsp_tag, lk_tag;
   logic [UW-1:0] rsp_sub, lk_sub;
   logic          lk_hit, lk_dir, lk_dly, lk_mem_en, lk_pat_en, cam_full;

   conn_cam u_conn_cam (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_stream(cmd_stream), .cmd_slot(cmd_slot), .cmd_tag(cmd_tag),
      .cmd_dir(cmd_dir), .cmd_pat(cmd_pat), .cmd_dly(cmd_dly), .cmd_sub(cmd_sub),
      .cmd_loc(cmd_loc), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_full(rsp_full),
      .rsp_loc(rsp_loc), .rsp_empty(rsp_empty), .rsp_stream(rsp_stream),
      .rsp_slot(rsp_slot), .rsp_tag(rsp_tag), .rsp_dir(rsp_dir), .rsp_pat(rsp_pat),
      .rsp_dly(rsp_dly), .rsp_sub(rsp_sub), .lk_valid(lk_valid), .lk_stream(lk_stream),
      .lk_slot(lk_slot), .lk_hit(lk_hit), .lk_loc(lk_loc), .lk_tag(lk_tag),
      .lk_dir(lk_dir), .lk_dly(lk_dly), .lk_sub(lk_sub), .lk_mem_en(lk_mem_en),
      .lk_pat_en(lk_pat_en), .cam_full(cam_full));

   // Reference model
   int m_empty [DEPTH];
   int m_stream[DEPTH], m_slot[DEPTH], m_tag[DEPTH];
   int m_dir[DEPTH], m_pat[DEPTH], m_dly[DEPTH], m_sub[DEPTH];

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string rq, string what, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // One clock: drive, predict from the pre-edge model, update, compare
   task automatic cycle(string rq);
      int e_ok = 0, e_full = 0, e_loc = 0, e_emp = 0, e_val = 0;
      int e_s = 0, e_t = 0, e_g = 0, e_d = 0, e_p = 0, e_y = 0, e_u = 0;
      int l_hit = 0, l_loc = 0, l_g = 0, l_d = 0, l_y = 0, l_u = 0, l_m = 0, l_p = 0;
      int any_empty = 0;
      if (lk_valid) begin
         for (int i = DEPTH - 1; i >= 0; i--)
            if (!m_empty[i] && m_stream[i] == lk_stream && m_slot[i] == lk_slot) begin
               l_hit = 1; l_loc = i; l_g = m_tag[i]; l_d = m_dir[i];
               l_y = m_dly[i]; l_u = m_sub[i]; l_p = m_pat[i]; l_m = !m_pat[i];
            end
      end
      if (cmd_valid && cmd_op != 2'b00) begin
         int f = -1;
         e_val = 1;
         if (cmd_op == 2'b01) begin
            for (int i = DEPTH - 1; i >= 0; i--) if (m_empty[i]) f = i;
            if (f < 0) e_full = 1;
            else begin
               e_ok = 1; e_loc = f; m_empty[f] = 0;
               m_stream[f] = cmd_stream; m_slot[f] = cmd_slot; m_tag[f] = cmd_tag;
               m_dir[f] = cmd_dir; m_pat[f] = cmd_pat; m_dly[f] = cmd_dly; m_sub[f] = cmd_sub;
            end
         end else if (cmd_op == 2'b10) begin
            for (int i = DEPTH - 1; i >= 0; i--)
               if (!m_empty[i] && m_stream[i] == cmd_stream && m_slot[i] == cmd_slot) f = i;
            if (f >= 0) begin
               e_ok = 1; e_loc = f; m_empty[f] = 1;
            end
         end else begin
            f = cmd_loc; e_ok = 1; e_loc = f; e_emp = m_empty[f];
         end
         if (e_ok) begin
            e_s = m_stream[f]; e_t = m_slot[f]; e_g = m_tag[f]; e_d = m_dir[f];
            e_p = m_pat[f]; e_y = m_dly[f]; e_u = m_sub[f];
         end
      end
      for (int i = 0; i < DEPTH; i++) if (m_empty[i]) any_empty = 1;
      @(posedge clk);
      @(negedge clk);
      chk(rq, "rsp_valid", rsp_valid, e_val);
      chk(rq, "rsp_ok", rsp_ok, e_ok);
      chk(rq, "rsp_full", rsp_full, e_full);
      chk(rq, "rsp_loc", rsp_loc, e_loc);
      chk(rq, "rsp_empty", rsp_empty, e_emp);
      chk(rq, "rsp_fields", {rsp_stream, rsp_slot, rsp_tag, rsp_dir, rsp_pat, rsp_dly, rsp_sub},
          {SW'(e_s), TW'(e_t), GW'(e_g), 1'(e_d), 1'(e_p), 1'(e_y), UW'(e_u)});
      chk(rq, "lk_hit", lk_hit, l_hit);
      chk(rq, "lk_loc", lk_loc, l_loc);
      chk(rq, "lk_fields", {lk_tag, lk_dir, lk_dly, lk_sub},
          {GW'(l_g), 1'(l_d), 1'(l_y), UW'(l_u)});
      chk(rq, "lk_mem_en", lk_mem_en, l_m);
      chk(rq, "lk_pat_en", lk_pat_en, l_p);
      chk(rq, "cam_full", cam_full, !any_empty);
      cmd_valid = 0; cmd_op = 0; lk_valid = 0;
   endtask

   task automatic set_make(int s, int t, int g, int d, int p, int y, int u);
      cmd_valid = 1; cmd_op = 2'b01; cmd_stream = SW'(s); cmd_slot = TW'(t);
      cmd_tag = GW'(g); cmd_dir = 1'(d); cmd_pat = 1'(p); cmd_dly = 1'(y); cmd_sub = UW'(u);
   endtask
   task automatic set_break(int s, int t);
      cmd_valid = 1; cmd_op = 2'b10; cmd_stream = SW'(s); cmd_slot = TW'(t);
   endtask
   task automatic set_query(int l);
      cmd_valid = 1; cmd_op = 2'b11; cmd_loc = IW'(l);
   endtask
   task automatic set_look(int s, int t);
      lk_valid = 1; lk_stream = SW'(s); lk_slot = TW'(t);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_empty[i] = 1; m_stream[i] = 0; m_slot[i] = 0; m_tag[i] = 0;
         m_dir[i] = 0; m_pat[i] = 0; m_dly[i] = 0; m_sub[i] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("R1", "cam_full", cam_full, 0);
      chk("R1", "rsp_valid", rsp_valid, 0);
      chk("R1", "lk_hit", lk_hit, 0);
      set_query(0);       cycle("R1");
      set_query(511);     cycle("R1");
      set_look(0, 0);     cycle("R1");
      // R2: allocation in order
      set_make(1, 5, 9'h1AB, 1, 0, 0, 2);   cycle("R2");
      set_make(3, 127, 9'h055, 0, 1, 1, 1); cycle("R2");
      set_make(31, 64, 9'h1FF, 1, 0, 1, 3); cycle("R2");
      // R6 / R8: normal and pattern hits, miss
      set_look(1, 5);     cycle("R6");
      set_look(3, 127);   cycle("R8");
      set_look(31, 64);   cycle("R8");
      set_look(2, 5);     cycle("R6");
      // R7: duplicate key, lowest wins
      set_make(1, 5, 9'h0C3, 0, 1, 0, 0);   cycle("R2");
      set_look(1, 5);     cycle("R7");
      set_break(1, 5);    cycle("R7");
      set_look(1, 5);     cycle("R7");
      // R2: hole refilled first
      set_make(7, 7, 9'h100, 1, 0, 0, 1);   cycle("R2");
      // R4: break miss leaves contents
      set_break(9, 9);    cycle("R4");
      set_query(3);       cycle("R5");
      // R9: lookup and break together
      set_look(3, 127); set_break(3, 127); cycle("R9");
      set_look(3, 127);   cycle("R9");
      // R9: lookup and make together
      set_look(4, 4); set_make(4, 4, 9'h0AA, 1, 0, 0, 0); cycle("R9");
      set_look(4, 4);     cycle("R6");
      // R5: queries leave state alone
      set_query(1);       cycle("R5");
      set_query(1);       cycle("R5");
      // R3: fill until full, then refused makes
      for (int i = 0; i < DEPTH; i++) begin
         set_make(i % 32, 1 + (i / 32), i % 512, i % 2, 0, (i / 2) % 2, i % 4);
         cycle("R3");
      end
      set_make(0, 0, 0, 1, 1, 1, 3);  cycle("R3");
      set_query(DEPTH - 1);           cycle("R3");
      set_look(5, 1);                 cycle("R6");
      set_break(31, 64);              cycle("R4");
      set_make(12, 12, 9'h1E1, 0, 1, 1, 2); cycle("R2");
      set_look(12, 12);               cycle("R8");
      repeat (2) cycle("R6");
      finish_run();
   end

endmodule